// File: doc/BRIEF.md
# Management-Bus Register Access Master

This block is a bus master that reads and writes 16-bit registers in a board-level controller. It uses a two-wire management bus in the clause-22 style: a clock line, a data line driven out with its own enable, and a separate data line coming back in. The host hands over one command at a time with a valid/ready handshake. A command holds a read/write flag, a 10-bit flat register address and, for a write, 16 bits of data. The master builds every field of the serial frame itself. It produces the bus clock from the system clock through a programmable divider, and it pulses done for one cycle when the access ends.

The flat address is split on the way out. The upper five bits select the device and the lower five bits select the register inside it. Registers at flat address 0x300 and above give an unreliable result on the first read. For those addresses the master runs two read frames back to back and returns only the result of the second. If no device answers during the turnaround of a read, the master clocks the bus for 32 extra cycles to flush it. It then returns all ones and raises a no-response flag.

Top module: `mgmt_reg_master`

## Requirements
- R1: After reset the bus clock is high, the data-out enable is low, busy is low, cmd_ready is high and done is low.
- R2: Every frame starts with 32 bus-clock cycles with the data line at 1. These are followed by the start pattern 01, then the opcode (10 for read, 01 for write), then the device field addr[9:5] and the register field addr[4:0], each sent MSB first. The outgoing data line changes only when the bus clock falls, never when it rises.
- R3: After the register field, a write frame drives the turnaround 10 and then the 16 data bits MSB first. It then releases the line for one more cycle, so the frame lasts 65 bus-clock cycles.
- R4: A read frame releases the line for two turnaround cycles and samples the second one on the rising bus clock. If that bit is 0, the master samples 16 data bits MSB first on the rising bus clock, then gives two trailing cycles, so the frame lasts 66 bus-clock cycles.
- R5: If the sampled turnaround bit of a read is 1, the master gives 32 further released cycles, so the frame lasts 80 cycles. It then returns rd_data = 0xFFFF with no_resp = 1.
- R6: A read of flat address 0x300 or above performs two read frames back to back and returns only the second result. A read at 0x2FF or below uses one frame.
- R7: Each low half and each high half of the bus clock inside a frame lasts HALF_DIV system clocks, and the bus clock stays high while the master is idle.
- R8: A command is accepted only in a cycle where cmd_ready is high. cmd_ready is low while busy, and a command presented while busy has no effect.
- R9: done is high for exactly one cycle at the end of each command, together with rd_data and no_resp. A write returns rd_data = 0 and no_resp = 0. busy is high from the cycle after acceptance until done.
- R10: The data-out enable is high only while the master drives the line: for 64 cycles of a write frame and 46 cycles of a read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle; command taken when valid is also high |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 10 | Flat register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rd_data | output | 16 | Read result, valid with done |
| no_resp | output | 1 | No device answered, valid with done |
| mdc | output | 1 | Bus clock |
| mdo | output | 1 | Outgoing bus data |
| mdo_en | output | 1 | Outgoing data enable for a tri-state pad |
| mdi | input | 1 | Incoming bus data |

## Verification
A behavioural device on the bus decodes every frame at the rising bus clock. It answers for all device addresses except 7, and it deliberately corrupts the first read of any high address unless that read directly follows a read of the same address.

Directed writes and reads at low addresses check field order, opcode and frame length. Reads at 0x2FF and 0x300 show whether the double-read threshold sits exactly at the boundary, and only a correct second read returns uncorrupted data. Accesses to the silent device separate the flush path from a normal read, both by the returned value and by the 80-cycle length. A command held on the inputs while busy, followed by a read-back, shows it was dropped. A seeded random mix of reads and writes across the whole address space is compared against a shadow copy kept in the bench.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  typedef enum logic [2:0] {
    E_IDLE,
    E_DRIVE,
    E_TA,
    E_DATA,
    E_TAIL
  } eng_st_t;

  typedef enum logic [1:0] {
    C_IDLE,
    C_FIRST,
    C_SECOND
  } ctl_st_t;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OPC_RD    = 2'b10;
  localparam logic [1:0] OPC_WR    = 2'b01;
  localparam logic [1:0] TA_WR     = 2'b10;
endpackage

// File: rtl/mgmt_half_timer.sv
module mgmt_half_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] hc_q, hc_n;

  assign tick = run && (hc_q == CW'(HALF_DIV - 1));

  always_comb begin
    if (!run || tick) hc_n = '0;
    else              hc_n = hc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc_q <= '0;
    else        hc_q <= hc_n;
  end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_pkg::*;
#(
  parameter int DEV_W       = 5,
  parameter int REG_W       = 5,
  parameter int DATA_W      = 16,
  parameter int PRE_BITS    = 32,
  parameter int FLUSH_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              wr,
  input  logic [DEV_W-1:0]  dev,
  input  logic [REG_W-1:0]  regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdi,
  output logic              mdc,
  output logic              mdo,
  output logic              mdo_en,
  output logic              running,
  output logic              fdone,
  output logic [DATA_W-1:0] f_rdata,
  output logic              f_nr
);
  localparam int HDR_BITS = PRE_BITS + 4 + DEV_W + REG_W;
  localparam int WR_BITS  = HDR_BITS + 2 + DATA_W;
  localparam int SLOT_W   = $clog2(WR_BITS + FLUSH_SLOTS);

  eng_st_t             st_q, st_n;
  logic [SLOT_W-1:0]   cnt_q, cnt_n, tail_q, tail_n;
  logic                ph_q, ph_n;
  logic [WR_BITS-1:0]  sr_q, sr_n, load_v;
  logic                mdc_q, mdc_n, mdo_q, mdo_n, en_q, en_n;
  logic                wr_q, wr_n, ta_q, ta_n, nr_q, nr_n, fd_q, fd_n;
  logic [DATA_W-1:0]   rd_q, rd_n;
  logic [SLOT_W-1:0]   last_drive;

  assign load_v = wr ? {{PRE_BITS{1'b1}}, START_PAT, OPC_WR, dev, regad, TA_WR, wdata}
                     : {{PRE_BITS{1'b1}}, START_PAT, OPC_RD, dev, regad, {(2 + DATA_W){1'b0}}};

  assign last_drive = wr_q ? SLOT_W'(WR_BITS - 1) : SLOT_W'(HDR_BITS - 1);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    tail_n = tail_q;
    ph_n   = ph_q;
    sr_n   = sr_q;
    mdc_n  = mdc_q;
    mdo_n  = mdo_q;
    en_n   = en_q;
    wr_n   = wr_q;
    ta_n   = ta_q;
    nr_n   = nr_q;
    rd_n   = rd_q;
    fd_n   = 1'b0;
    if (st_q == E_IDLE) begin
      if (start) begin
        st_n  = E_DRIVE;
        cnt_n = '0;
        ph_n  = 1'b0;
        sr_n  = load_v;
        mdc_n = 1'b0;
        mdo_n = load_v[WR_BITS-1];
        en_n  = 1'b1;
        wr_n  = wr;
        nr_n  = 1'b0;
        ta_n  = 1'b0;
        rd_n  = '0;
      end
    end else if (tick) begin
      if (!ph_q) begin
        // rising bus clock: sampling point
        ph_n  = 1'b1;
        mdc_n = 1'b1;
        if (st_q == E_TA && cnt_q == SLOT_W'(1)) ta_n = mdi;
        if (st_q == E_DATA) rd_n = {rd_q[DATA_W-2:0], mdi};
      end else begin
        // falling bus clock: next slot begins, data may change
        ph_n  = 1'b0;
        mdc_n = 1'b0;
        cnt_n = cnt_q + 1'b1;
        case (st_q)
          E_DRIVE: begin
            sr_n  = {sr_q[WR_BITS-2:0], 1'b0};
            mdo_n = sr_q[WR_BITS-2];
            if (cnt_q == last_drive) begin
              cnt_n = '0;
              en_n  = 1'b0;
              mdo_n = 1'b1;
              if (wr_q) begin
                st_n   = E_TAIL;
                tail_n = SLOT_W'(1);
              end else begin
                st_n = E_TA;
              end
            end
          end
          E_TA: begin
            if (cnt_q == SLOT_W'(1)) begin
              cnt_n = '0;
              if (ta_q) begin
                st_n   = E_TAIL;
                tail_n = SLOT_W'(FLUSH_SLOTS);
                nr_n   = 1'b1;
                rd_n   = '1;
              end else begin
                st_n = E_DATA;
              end
            end
          end
          E_DATA: begin
            if (cnt_q == SLOT_W'(DATA_W - 1)) begin
              cnt_n  = '0;
              st_n   = E_TAIL;
              tail_n = SLOT_W'(2);
            end
          end
          E_TAIL: begin
            if (cnt_q == tail_q - 1'b1) begin
              st_n  = E_IDLE;
              cnt_n = '0;
              mdc_n = 1'b1;
              fd_n  = 1'b1;
            end
          end
          default: st_n = E_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      cnt_q  <= '0;
      tail_q <= '0;
      ph_q   <= 1'b0;
      sr_q   <= '0;
      mdc_q  <= 1'b1;
      mdo_q  <= 1'b1;
      en_q   <= 1'b0;
      wr_q   <= 1'b0;
      ta_q   <= 1'b0;
      nr_q   <= 1'b0;
      rd_q   <= '0;
      fd_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      tail_q <= tail_n;
      ph_q   <= ph_n;
      sr_q   <= sr_n;
      mdc_q  <= mdc_n;
      mdo_q  <= mdo_n;
      en_q   <= en_n;
      wr_q   <= wr_n;
      ta_q   <= ta_n;
      nr_q   <= nr_n;
      rd_q   <= rd_n;
      fd_q   <= fd_n;
    end
  end

  assign mdc     = mdc_q;
  assign mdo     = mdo_q;
  assign mdo_en  = en_q;
  assign running = (st_q != E_IDLE);
  assign fdone   = fd_q;
  assign f_rdata = rd_q;
  assign f_nr    = nr_q;

  // R2: outgoing line is never changed on the rising bus clock
  p_rise_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> ($stable(mdo_q) && $stable(en_q)));

  // R6: a new frame is only launched into an idle engine
  p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == E_IDLE));
endmodule

// File: rtl/mgmt_access_ctrl.sv
module mgmt_access_ctrl
  import mgmt_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int REG_W     = 5,
  parameter int DATA_W    = 16,
  parameter int HIGH_BASE = 'h300
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic                    cmd_write,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [DATA_W-1:0]       cmd_wdata,
  output logic                    cmd_ready,
  output logic                    busy,
  output logic                    done,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    no_resp,
  output logic                    eng_start,
  output logic                    eng_wr,
  output logic [ADDR_W-REG_W-1:0] eng_dev,
  output logic [REG_W-1:0]        eng_reg,
  output logic [DATA_W-1:0]       eng_wdata,
  input  logic                    fdone,
  input  logic [DATA_W-1:0]       f_rdata,
  input  logic                    f_nr
);
  ctl_st_t           st_q, st_n;
  logic              wr_q, wr_n, dbl_q, dbl_n, start_q, start_n, done_q, done_n, nr_q, nr_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wd_q, wd_n, rdat_q, rdat_n;
  logic              finish;

  always_comb begin
    st_n    = st_q;
    wr_n    = wr_q;
    dbl_n   = dbl_q;
    addr_n  = addr_q;
    wd_n    = wd_q;
    start_n = 1'b0;
    done_n  = 1'b0;
    rdat_n  = rdat_q;
    nr_n    = nr_q;
    finish  = 1'b0;
    case (st_q)
      C_IDLE: begin
        if (cmd_valid) begin
          st_n    = C_FIRST;
          wr_n    = cmd_write;
          addr_n  = cmd_addr;
          wd_n    = cmd_wdata;
          dbl_n   = !cmd_write && (cmd_addr >= ADDR_W'(HIGH_BASE));
          start_n = 1'b1;
        end
      end
      C_FIRST: begin
        if (fdone) begin
          if (dbl_q) begin
            st_n    = C_SECOND;
            start_n = 1'b1;
          end else begin
            finish = 1'b1;
          end
        end
      end
      C_SECOND: if (fdone) finish = 1'b1;
      default: st_n = C_IDLE;
    endcase
    if (finish) begin
      st_n   = C_IDLE;
      done_n = 1'b1;
      rdat_n = wr_q ? '0 : f_rdata;
      nr_n   = !wr_q && f_nr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= C_IDLE;
      wr_q    <= 1'b0;
      dbl_q   <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      rdat_q  <= '0;
      nr_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      wr_q    <= wr_n;
      dbl_q   <= dbl_n;
      addr_q  <= addr_n;
      wd_q    <= wd_n;
      start_q <= start_n;
      done_q  <= done_n;
      rdat_q  <= rdat_n;
      nr_q    <= nr_n;
    end
  end

  assign cmd_ready = (st_q == C_IDLE);
  assign busy      = (st_q != C_IDLE);
  assign done      = done_q;
  assign rd_data   = rdat_q;
  assign no_resp   = nr_q;
  assign eng_start = start_q;
  assign eng_wr    = wr_q;
  assign eng_dev   = addr_q[ADDR_W-1:REG_W];
  assign eng_reg   = addr_q[REG_W-1:0];
  assign eng_wdata = wd_q;

  // R8: an accepted command makes the master busy and closes the handshake
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));

  // R9: done is a single-cycle pulse
  p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: a missing device always reports all ones
  p_noresp_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_resp) |-> (rd_data == '1));
endmodule

// File: rtl/mgmt_reg_master.sv
module mgmt_reg_master #(
  parameter int HALF_DIV    = 4,
  parameter int ADDR_W      = 10,
  parameter int REG_W       = 5,
  parameter int DATA_W      = 16,
  parameter int PRE_BITS    = 32,
  parameter int FLUSH_SLOTS = 32,
  parameter int HIGH_BASE   = 'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              no_resp,
  output logic              mdc,
  output logic              mdo,
  output logic              mdo_en,
  input  logic              mdi
);
  localparam int DEV_W = ADDR_W - REG_W;

  logic              tick, eng_run, eng_start, eng_wr, fdone, f_nr;
  logic [DEV_W-1:0]  eng_dev;
  logic [REG_W-1:0]  eng_reg;
  logic [DATA_W-1:0] eng_wdata, f_rdata;

  mgmt_access_ctrl #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W), .HIGH_BASE(HIGH_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_ready(cmd_ready), .busy(busy), .done(done), .rd_data(rd_data), .no_resp(no_resp),
    .eng_start(eng_start), .eng_wr(eng_wr), .eng_dev(eng_dev), .eng_reg(eng_reg),
    .eng_wdata(eng_wdata), .fdone(fdone), .f_rdata(f_rdata), .f_nr(f_nr)
  );

  mgmt_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(eng_run), .tick(tick)
  );

  mgmt_frame_engine #(
    .DEV_W(DEV_W), .REG_W(REG_W), .DATA_W(DATA_W),
    .PRE_BITS(PRE_BITS), .FLUSH_SLOTS(FLUSH_SLOTS)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(eng_start), .wr(eng_wr),
    .dev(eng_dev), .regad(eng_reg), .wdata(eng_wdata), .mdi(mdi),
    .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en), .running(eng_run),
    .fdone(fdone), .f_rdata(f_rdata), .f_nr(f_nr)
  );

  // R7: while the master is idle the bus clock rests high and the line is released
  p_idle_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (mdc && !mdo_en));
endmodule

// File: tb/mgmt_reg_master_bench.sv
module mgmt_reg_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HDIV       = 2;

  logic clk, rst_n;
  logic cmd_valid, cmd_ready, cmd_write, busy, done, no_resp;
  logic [9:0]  cmd_addr;
  logic [15:0] cmd_wdata, rd_data;
  logic mdc, mdo, mdo_en, mdi;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mgmt_reg_master #(.HALF_DIV(HDIV)) u_mgmt_reg_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .no_resp(no_resp),
    .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en), .mdi(mdi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural bus device ----------------
  logic [15:0] dmem [1024];
  logic [15:0] shadow [1024];
  logic [63:0] cap;
  int   k = 0;
  logic prev_en = 1'b0;
  logic dread = 1'b0, present = 1'b0, prev_rd = 1'b0, hdr_ok = 1'b0;
  logic [1:0]  d_op = 2'b00, d_ta = 2'b00;
  logic [9:0]  daddr = '0, prev_addr = '0;
  logic [15:0] rval = '0;
  logic nxt_mdi = 1'b1;
  int   en_cnt = 0;
  int   falls = 0;

  function automatic logic [15:0] init_val(input int i);
    return 16'(i * 16'h3B1) ^ 16'h1234;
  endfunction

  always @(posedge mdc) begin
    int s;
    if (mdo_en && !prev_en) begin k = 0; en_cnt = 0; end
    else k = k + 1;
    prev_en = mdo_en;
    if (mdo_en) en_cnt = en_cnt + 1;
    if (k < 64 && mdo_en) cap[63-k] = mdo;
    if (k == 45) begin
      hdr_ok  = (cap[63:32] == 32'hFFFF_FFFF) && (cap[31:30] == 2'b01);
      d_op    = cap[29:28];
      dread   = (cap[29:28] == 2'b10);
      daddr   = {cap[27:23], cap[22:18]};
      present = (cap[27:23] != 5'd7);
      rval    = dmem[daddr];
      if (daddr >= 10'h300 && !(prev_rd && prev_addr == daddr)) rval = rval ^ 16'h5A5A;
      prev_rd   = dread;
      prev_addr = daddr;
    end
    if (k == 63 && !dread) begin
      d_ta = cap[17:16];
      if (present) dmem[daddr] = cap[15:0];
    end
    s = k + 1;
    nxt_mdi = 1'b1;
    if (dread && present && k >= 45) begin
      if (s == 47) nxt_mdi = 1'b0;
      else if (s >= 48 && s <= 63) nxt_mdi = rval[63-s];
    end
  end

  always @(negedge mdc) begin
    mdi = nxt_mdi;
    falls = falls + 1;
  end

  // ---------------- bus clock half-period monitor (R7) ----------------
  int run_len = 0, low_min = 9999, low_max = 0, high_min = 9999;
  logic last_mdc = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc != last_mdc) begin
        if (last_mdc == 1'b0) begin
          if (run_len < low_min) low_min = run_len;
          if (run_len > low_max) low_max = run_len;
        end else if (run_len < high_min) high_min = run_len;
        run_len = 1;
      end else run_len = run_len + 1;
      last_mdc = mdc;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_slots(input logic w, input logic [9:0] a);
    int one;
    if (w) return 65;
    one = (a[9:5] == 5'd7) ? 80 : 66;
    return (a >= 10'h300) ? 2 * one : one;
  endfunction

  logic seen_busy, done_after;

  task automatic do_cmd(input logic w, input logic [9:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output logic nr, output int slots);
    int f0, guard;
    guard = 0;
    while (!cmd_ready && guard < 5000) begin @(negedge clk); guard++; end
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    f0 = falls;
    @(negedge clk);
    cmd_valid = 1'b0;
    seen_busy = busy;
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    rd = rd_data; nr = no_resp; slots = falls - f0;
    @(negedge clk);
    done_after = done;
  endtask

  task automatic check_access(input logic w, input logic [9:0] a, input logic [15:0] d);
    logic [15:0] rd; logic nr; int sl;
    logic [15:0] exp_d; logic exp_nr;
    do_cmd(w, a, d, rd, nr, sl);
    if (w) begin
      exp_d = 16'h0; exp_nr = 1'b0;
      if (a[9:5] != 5'd7) shadow[a] = d;
    end else if (a[9:5] == 5'd7) begin
      exp_d = 16'hFFFF; exp_nr = 1'b1;
    end else begin
      exp_d = shadow[a]; exp_nr = 1'b0;
    end
    chk(rd == exp_d, w ? "R9 write rd_data" : (a >= 10'h300 ? "R6 read data" : "R4 read data"), rd, exp_d);
    chk(nr == exp_nr, exp_nr ? "R5 no_resp" : "R9 no_resp", nr, exp_nr);
    chk(sl == exp_slots(w, a), w ? "R3 frame length" : (a >= 10'h300 ? "R6 frame length" : "R5 R4 frame length"),
        sl, exp_slots(w, a));
    chk(seen_busy == 1'b1, "R9 busy after accept", seen_busy, 1);
    chk(done_after == 1'b0, "R9 done one cycle", done_after, 0);
    chk(hdr_ok == 1'b1, "R2 preamble and start", hdr_ok, 1);
    chk(daddr == a, "R2 address split", daddr, a);
    chk(d_op == (w ? 2'b01 : 2'b10), "R2 opcode", d_op, w ? 2'b01 : 2'b10);
    chk(en_cnt == (w ? 64 : 46), "R10 drive enable span", en_cnt, w ? 64 : 46);
    if (w) chk(d_ta == 2'b10, "R3 turnaround", d_ta, 2'b10);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 1024; i++) begin
      dmem[i]   = init_val(i);
      shadow[i] = init_val(i);
    end
    mdi = 1'b1;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mdc == 1'b1, "R1 mdc", mdc, 1);
    chk(mdo_en == 1'b0, "R1 mdo_en", mdo_en, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed: write then read back, low address
    check_access(1'b1, 10'h00A, 16'h0001);
    check_access(1'b0, 10'h00A, 16'h0);
    check_access(1'b1, 10'h04E, 16'hBEEF);
    check_access(1'b0, 10'h04E, 16'h0);
    // silent device (device field 7)
    check_access(1'b0, 10'h0E5, 16'h0);
    check_access(1'b1, 10'h0E1, 16'h1111);
    // double-read threshold
    check_access(1'b0, 10'h2FF, 16'h0);
    check_access(1'b0, 10'h300, 16'h0);
    check_access(1'b0, 10'h3FF, 16'h0);

    // R8: command held while busy must be dropped
    begin
      logic [15:0] rd; logic nr; int sl; int guard; bit ready_low;
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 10'h011; cmd_wdata = 16'hAAAA;
      shadow[10'h011] = 16'hAAAA;
      @(negedge clk);
      cmd_addr = 10'h012; cmd_wdata = 16'h5555;
      ready_low = 1'b1;
      for (int j = 0; j < 20; j++) begin
        if (cmd_ready) ready_low = 1'b0;
        @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk(ready_low, "R8 ready low while busy", ready_low, 1);
      guard = 0;
      while (!done && guard < 20000) begin @(negedge clk); guard++; end
      @(negedge clk);
      do_cmd(1'b0, 10'h012, 16'h0, rd, nr, sl);
      chk(rd == shadow[10'h012], "R8 ignored write", rd, shadow[10'h012]);
      do_cmd(1'b0, 10'h011, 16'h0, rd, nr, sl);
      chk(rd == 16'hAAAA, "R8 accepted write", rd, 16'hAAAA);
    end

    // constrained random mix
    for (int n = 0; n < 40; n++) begin
      logic w; logic [9:0] a; logic [15:0] d;
      a = 10'($urandom_range(0, 1023));
      w = ($urandom_range(0, 1) == 1) && (a < 10'h300);
      d = 16'($urandom);
      check_access(w, a, d);
    end

    chk(low_min == HDIV && low_max == HDIV, "R7 low half length", low_max, HDIV);
    chk(high_min == HDIV, "R7 high half length", high_min, HDIV);
    chk(mdc == 1'b1, "R7 idle high", mdc, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule